// File: doc/BRIEF.md
# DDS Programming Front End and Phase Accumulator

This block sits at the input of a direct digital synthesizer. A host writes a 40-bit control word over an 8-bit data bus. The word holds a 32-bit frequency tuning word and an 8-bit control byte. Each write is marked by a write strobe. The word can arrive in one of two ways:

- **Parallel:** five bytes, one per strobe.
- **Serial:** forty single bits on the top data line.

The collected word is held in a pending register. It has no effect on the output until an update strobe copies it into the active register.

On every system clock a 32-bit phase accumulator adds the active tuning word. The output frequency is therefore the tuning word times the clock rate divided by 2^32. The top 14 accumulator bits, shifted by a 5-bit phase offset taken from the control byte, form the phase output. A later sine stage consumes this output.

Both strobes are asynchronous to the system clock. The block resynchronizes them and acts on their rising edges. Serial mode is entered through a special control code and stays on until reset.

Top module: `dds_front`

## Requirements
- R1: While `rst` is high and after it is released with no update, `phase_out` is 0.
- R2: On every clock the accumulator adds the active 32-bit tuning word, modulo 2^32. `phase_out` equals accumulator bits [31:18] plus (control[7:3] << 9), modulo 2^14.
- R3: In parallel mode the first write after reset or after an update lands in the control byte. The next four writes fill the tuning word from bits [31:24] down to bits [7:0].
- R4: In parallel mode, writes after the fifth are ignored until the next update or reset.
- R5: Writes without an update leave `phase_out` on its existing course.
- R6: A rising edge on `upd_strobe` copies the pending word into the active register at the third rising clock edge after the input rises. It also returns the byte pointer to zero.
- R7: Control bits [7:3] give a phase offset in steps of 1/32 of a cycle, added at `phase_out` bit 9 and above.
- R8: An update in parallel mode whose control bits [2:0] equal 3'b011 switches the block to serial mode. In serial mode each write shifts in `data_in[7]`. The first bit received ends up in tuning-word bit 0, and the last eight bits received form the control byte.
- R9: Serial mode stays on through later updates of any control value and ends only at reset.
- R10: If write and update edges are detected in the same cycle, the update commits the word as it stood before. The concurrent write is discarded, and the next parallel write lands in the control byte.
- R11: Reset clears the pending word, pointer and serial flag, so an update right after reset commits an all-zero word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | Asynchronous write strobe, acts on its rising edge |
| upd_strobe | input | 1 | Asynchronous update strobe, acts on its rising edge |
| data_in | input | 8 | Byte in parallel mode; bit 7 is the serial line |
| phase_out | output | 14 | Truncated, offset phase |

## Verification
The write path and the commit path can both act in the same system clock cycle. This happens when the two strobes rise together, because they pass through identical synchronizers. The bench raises both inputs in the same cycle. It then checks two things:

- the committed word, seen through `phase_out`, is the one collected before that cycle;
- a follow-up byte lands in the control position, which shows the concurrent write was dropped and the pointer reset.

A cycle-exact reference accumulator judges every cycle of output.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int FTW_W        = 32;
    localparam int CTL_W        = 8;
    localparam int BUS_W        = 8;
    localparam int PHASE_OUT_W  = 14;
    localparam int OFFSET_W     = 5;
    localparam int SER_CODE_W   = 3;
    localparam logic [SER_CODE_W-1:0] SER_CODE = 3'b011;
    localparam int WORD_W       = FTW_W + CTL_W;
    localparam int NUM_BYTES    = WORD_W / BUS_W;
    localparam int PTR_W        = $clog2(NUM_BYTES + 1);

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [FTW_W-1:0] ftw;
    } ctl_word_t;

    function automatic logic is_serial_code(input logic [CTL_W-1:0] c);
        return c[SER_CODE_W-1:0] == SER_CODE;
    endfunction

    function automatic logic [OFFSET_W-1:0] phase_offset(input logic [CTL_W-1:0] c);
        return c[CTL_W-1 -: OFFSET_W];
    endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;

    // R6: an edge yields exactly one single-cycle pulse
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !(rise && $past(rise)));
endmodule

// File: rtl/word_loader.sv
module word_loader import dds_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_rise,
    input  logic             upd_rise,
    input  logic [BUS_W-1:0] data,
    output ctl_word_t        active
);
    logic [WORD_W-1:0] pending;
    logic [WORD_W-1:0] load_nxt;
    logic [PTR_W-1:0]  ptr;
    logic              serial_q;

    always_comb begin
        load_nxt = pending;
        if (serial_q) begin
            load_nxt = {data[BUS_W-1], pending[WORD_W-1:1]};
        end else begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (ptr == PTR_W'(b))
                    load_nxt[WORD_W-1-b*BUS_W -: BUS_W] = data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= '0;
            active   <= '0;
            ptr      <= '0;
            serial_q <= 1'b0;
        end else if (upd_rise) begin
            active <= ctl_word_t'(pending);
            ptr    <= '0;
            if (!serial_q && is_serial_code(pending[WORD_W-1 -: CTL_W]))
                serial_q <= 1'b1;
        end else if (wr_rise) begin
            pending <= load_nxt;
            if (!serial_q && ptr < PTR_W'(NUM_BYTES))
                ptr <= ptr + 1'b1;
        end
    end

    // R4: pointer never runs past the last byte slot
    assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(NUM_BYTES));
    // R9: serial mode never drops except through reset
    assert_serial_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !$fell(serial_q));
    // R6: commit copies the pending word
    assert_commit_copy_R6: assert property (@(posedge clk) disable iff (rst)
        upd_rise |=> active == ctl_word_t'($past(pending)));
    // R10: update wins over a same-cycle write and rewinds the pointer
    assert_update_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (upd_rise && wr_rise) |=> (ptr == '0 && pending == $past(pending)));
    // R8: serial write places the line bit at the top of the shift register
    assert_serial_shift_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_rise && !upd_rise && serial_q) |=> pending[WORD_W-1] == $past(data[BUS_W-1]));
endmodule

// File: rtl/phase_accum.sv
module phase_accum import dds_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  ctl_word_t              active,
    output logic [PHASE_OUT_W-1:0] phase_out
);
    localparam int OFF_SHIFT = PHASE_OUT_W - OFFSET_W;

    logic [FTW_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc + active.ftw;
    end

    assign phase_out = acc[FTW_W-1 -: PHASE_OUT_W]
                     + (PHASE_OUT_W'(phase_offset(active.ctl)) << OFF_SHIFT);

    // R2: accumulator advances by the previous cycle's tuning word
    assert_acc_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> acc == $past(acc) + $past(active.ftw));
    // R1: reset leaves the accumulator at zero
    assert_acc_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> acc == '0);
endmodule

// File: rtl/dds_front.sv
module dds_front import dds_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_strobe,
    input  logic                   upd_strobe,
    input  logic [BUS_W-1:0]       data_in,
    output logic [PHASE_OUT_W-1:0] phase_out
);
    logic      wr_rise;
    logic      upd_rise;
    ctl_word_t active;

    edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .async_in(wr_strobe), .rise(wr_rise));

    edge_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
        .clk(clk), .rst(rst), .async_in(upd_strobe), .rise(upd_rise));

    word_loader u_loader (
        .clk(clk), .rst(rst), .wr_rise(wr_rise), .upd_rise(upd_rise),
        .data(data_in), .active(active));

    phase_accum u_accum (
        .clk(clk), .rst(rst), .active(active), .phase_out(phase_out));
endmodule

// File: tb/sim_dds_front.sv
module sim_dds_front;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_strobe = 1'b0;
    logic        upd_strobe = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic [13:0] phase_out;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R1";
    logic mon_on = 1'b0;

    // bench-side view of the requirements
    logic [39:0] b_pending;
    int          b_ptr;
    logic        b_serial;
    logic [39:0] exp_q[$];

    // reference accumulator
    logic [31:0] m_acc;
    logic [39:0] m_act;
    logic        h1, h2, h3;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_front u0 (
        .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .upd_strobe(upd_strobe),
        .data_in(data_in), .phase_out(phase_out));

    // R6: commit lands on the third clock edge after the update input rises
    always @(posedge clk) begin
        if (rst) begin
            m_acc <= '0; m_act <= '0; h1 <= 0; h2 <= 0; h3 <= 0;
        end else begin
            h1 <= upd_strobe; h2 <= h1; h3 <= h2;
            m_acc <= m_acc + m_act[31:0];
            if (h2 && !h3) begin
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R6: commit seen, actual unexpected, expected none queued");
                end else begin
                    m_act <= exp_q.pop_front();
                end
            end
        end
    end

    // monitor: compare every cycle away from the edge
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            logic [13:0] expv;
            expv = m_acc[31:18] + {m_act[39:35], 9'b0};
            vectors++;
            if (phase_out !== expv) begin
                errors++;
                $display("FAIL %s R2: phase_out actual %h expected %h", cur_req, phase_out, expv);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_strobe = 0; upd_strobe = 0;
        idle(3);
        exp_q.delete();
        b_pending = '0; b_ptr = 0; b_serial = 0;
        rst = 1'b0;
        idle(3);
    endtask

    task automatic model_write(input logic [7:0] d);
        if (b_serial) b_pending = {d[7], b_pending[39:1]};
        else if (b_ptr < 5) begin
            b_pending[39-8*b_ptr -: 8] = d;
            b_ptr++;
        end
    endtask

    task automatic model_commit();
        exp_q.push_back(b_pending);
        if (!b_serial && b_pending[34:32] == 3'b011) b_serial = 1;
        b_ptr = 0;
    endtask

    task automatic write_byte(input logic [7:0] d);
        model_write(d);
        data_in = d; wr_strobe = 1;
        idle(HOLD);
        wr_strobe = 0;
        idle(HOLD);
    endtask

    task automatic commit();
        model_commit();
        upd_strobe = 1;
        idle(HOLD);
        upd_strobe = 0;
        idle(HOLD);
    endtask

    task automatic write_and_commit(input logic [7:0] d);
        model_commit();     // R10: write is discarded
        data_in = d; wr_strobe = 1; upd_strobe = 1;
        idle(HOLD);
        wr_strobe = 0; upd_strobe = 0;
        idle(HOLD);
    endtask

    task automatic load_parallel(input logic [7:0] ctl, input logic [31:0] f);
        write_byte(ctl);
        for (int i = 3; i >= 0; i--) write_byte(f[8*i +: 8]);
    endtask

    task automatic load_serial(input logic [39:0] w);
        for (int i = 0; i < 40; i++) write_byte({w[i], 7'(8'h5A ^ 8'(i))});
    endtask

    task automatic check_phase(input string req, input logic [13:0] expv);
        vectors++;
        if (phase_out !== expv) begin
            errors++;
            $display("FAIL %s: phase_out actual %h expected %h", req, phase_out, expv);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        b_pending = '0; b_ptr = 0; b_serial = 0;
        idle(2);
        check_phase("R1", 14'h0);
        do_reset();
        mon_on = 1;
        cur_req = "R1"; idle(10);
        check_phase("R1", 14'h0);

        // R11: immediate update after reset commits zero
        cur_req = "R11"; commit(); idle(10);
        check_phase("R11", 14'h0);

        // R3 / R2: parallel load, MSB-first frequency bytes
        cur_req = "R3"; load_parallel(8'h00, 32'h0123_4567); commit(); idle(30);

        // R5: loading without update keeps the course
        cur_req = "R5"; load_parallel(8'hF8, 32'h7FFF_0000); idle(40);
        commit(); idle(20);

        // R7: phase offset
        cur_req = "R7"; load_parallel(8'hA8, 32'h0004_0000); commit(); idle(20);

        // R4: extra bytes ignored
        cur_req = "R4"; load_parallel(8'h10, 32'h0200_0001);
        write_byte(8'hEE); write_byte(8'h77); commit(); idle(20);

        // R10: simultaneous write and update
        cur_req = "R10"; load_parallel(8'h20, 32'h0010_0000);
        write_and_commit(8'h99); idle(10);
        load_parallel(8'h48, 32'h0008_0000); commit(); idle(20);

        // R8: enter serial mode, then load LSB first
        cur_req = "R8"; load_parallel(8'h03, 32'h0003_0000); commit(); idle(10);
        load_serial({8'h58, 32'h1357_9BDF}); commit(); idle(30);

        // R9: update with a non-code control keeps serial mode
        cur_req = "R9"; load_serial({8'hB0, 32'h0040_0000}); commit(); idle(10);
        load_serial({8'h08, 32'h00C0_0000}); commit(); idle(30);

        // R9: reset restores parallel mode
        do_reset();
        cur_req = "R9"; check_phase("R9", 14'h0);
        load_parallel(8'h18, 32'h0100_0000); commit(); idle(30);

        mon_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule